// File: doc/BRIEF.md
# IQ Datapath Sample Access Port

This block gives a host a byte-wide register window onto the transmit I and Q samples of a modulator. The window sits at the point just after the correction stage. Each channel carries a 14-bit sample. A read lets software observe the live value. A write supplies a replacement value for the downstream converter input.

The bus is simple: an address, a read strobe, a write strobe, write data and registered read data. Each channel owns two consecutive byte locations, low byte first and then high byte, with I before Q. Reading a low byte also copies the matching high bits into a per-channel holding register. The following high-byte read then returns bits from the same sample, even if the live value has moved on.

Host writes are assembled in two steps. The low byte is staged, and the high-byte write commits the full value. The committed value reaches the converter only while the external override select is high. Otherwise the converter input tracks the live stream on each sample strobe.

Top module: `iq_tap_port`

## Requirements
- R1: The map holds four locations starting at BASE_ADDR (default 0x50), in this order: 0x50 I low, 0x51 I high, 0x52 Q low, 0x53 Q high. A read strobe updates `bus_rdata` at that clock edge, so it is visible from the next cycle, and the value holds until the next read.
- R2: A low-byte read returns bits 7:0 of the channel's live sample as present at the read edge.
- R3: A low-byte read copies bits 13:8 of the same live sample into that channel's holding register. A later high-byte read returns the held bits in data bits 5:0, whatever the live value is by then.
- R4: A high-byte read that no low-byte read has preceded returns the last held value. After reset the held value is zero.
- R5: Bits 7:6 of a high-byte read are always zero. Bits 7:6 written to a high-byte location have no effect on the override value.
- R6: A low-byte write is only staged. The channel's 14-bit override value changes only on a high-byte write, becoming {wdata[5:0], staged low byte}.
- R7: While `ovr_sel` is 1, each converter output equals its channel's override value. A committed write shows up two clock edges after the high-byte write strobe, and live strobes do not change the output.
- R8: While `ovr_sel` is 0, each converter output loads the live sample on each edge where `live_stb` is 1, so it is visible in the next cycle. It holds its value when no strobe occurs.
- R9: A read at any address outside the four locations returns 0x00 and leaves the holding registers unchanged. A write to such an address changes no override or staged value.
- R10: Reset clears the read data, the converter outputs, the holding registers, the staged bytes and the override values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovr_sel | input | 1 | Selects host-written values for the converter |
| live_stb | input | 1 | Sample strobe of the live datapath |
| live_i | input | 14 | Live I sample after correction |
| live_q | input | 14 | Live Q sample after correction |
| dac_i | output | 14 | Converter input, I channel |
| dac_q | output | 14 | Converter input, Q channel |

## Verification
The read path is swept over several hundred spread 14-bit values per channel, with I and Q given different values. Between the low and high reads the live value is changed, so a high byte taken live rather than from the holding register cannot go unnoticed. It also shows whether the I and Q channels or their byte halves have been crossed.

The override path is driven with a staged-low-then-high sequence and checked after each half. This separates staging from commit, and it also shows whether reserved bits leak through. Live strobes with the override on and off show whether the select gates the converter. Reads and writes around the map boundary (0x4F, 0x54 and the extremes) confirm that addresses outside the map leave all state untouched.

// File: rtl/iq_tap_pkg.sv
package iq_tap_pkg;
   // Slot order is behavioural: low byte before high byte, I before Q.
   typedef enum logic [1:0] {
      SLOT_I_LO = 2'd0,
      SLOT_I_HI = 2'd1,
      SLOT_Q_LO = 2'd2,
      SLOT_Q_HI = 2'd3
   } slot_e;

   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned NUM_SLOT = 4;
endpackage

// File: rtl/iq_tap_decode.sv
module iq_tap_decode
   import iq_tap_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic              hit,
   output slot_e             slot,
   output logic [NUM_CH-1:0] rd_lo,
   output logic [NUM_CH-1:0] wr_lo,
   output logic [NUM_CH-1:0] wr_hi
);
   logic [ADDR_W-1:0] offset;

   assign offset = bus_addr - BASE_ADDR;
   assign hit    = (bus_addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_SLOT));
   assign slot   = slot_e'(offset[1:0]);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_lo, sel_hi;
      assign sel_lo   = hit && (offset[1:0] == 2'(2*c));
      assign sel_hi   = hit && (offset[1:0] == 2'(2*c+1));
      assign rd_lo[c] = bus_rd && sel_lo;
      assign wr_lo[c] = bus_wr && sel_lo;
      assign wr_hi[c] = bus_wr && sel_hi;
   end
endmodule

// File: rtl/iq_tap_lane.sv
module iq_tap_lane #(
   parameter int unsigned SAMPLE_W = 14,
   parameter int unsigned DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                live_stb,
   input  logic [SAMPLE_W-1:0] live,
   input  logic                ovr_sel,
   input  logic                rd_lo,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   lo_byte,
   output logic [DATA_W-1:0]   hi_byte,
   output logic [SAMPLE_W-1:0] dac
);
   localparam int unsigned HI_W = SAMPLE_W - DATA_W;

   logic [HI_W-1:0]     hold_q;
   logic [DATA_W-1:0]   stage_q;
   logic [SAMPLE_W-1:0] ovr_q;

   // Snapshot of the upper bits, taken together with the low byte.
   always_ff @(posedge clk) begin
      if (!rst_n)     hold_q <= '0;
      else if (rd_lo) hold_q <= live[SAMPLE_W-1:DATA_W];
   end

   // Two-step override assembly: low byte staged, high byte commits.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         ovr_q   <= '0;
      end else begin
         if (wr_lo) stage_q <= wdata;
         if (wr_hi) ovr_q   <= {wdata[HI_W-1:0], stage_q};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        dac <= '0;
      else if (ovr_sel)  dac <= ovr_q;
      else if (live_stb) dac <= live;
   end

   assign lo_byte = live[DATA_W-1:0];

   if (DATA_W > HI_W) begin : g_pad
      assign hi_byte = {{(DATA_W-HI_W){1'b0}}, hold_q};
   end else begin : g_nopad
      assign hi_byte = hold_q;
   end

   p_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> hi_byte[HI_W-1:0] == $past(live[SAMPLE_W-1:DATA_W]));

   p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_sel && live_stb) |=> dac == $past(live));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_sel && !live_stb) |=> $stable(dac));

   p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_sel && $past(ovr_sel) && !$past(wr_hi) && !wr_hi) |=> $stable(dac));
endmodule

// File: rtl/iq_tap_port.sv
module iq_tap_port
   import iq_tap_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 14,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                ovr_sel,
   input  logic                live_stb,
   input  logic [SAMPLE_W-1:0] live_i,
   input  logic [SAMPLE_W-1:0] live_q,
   output logic [SAMPLE_W-1:0] dac_i,
   output logic [SAMPLE_W-1:0] dac_q
);
   localparam int unsigned HI_W = SAMPLE_W - DATA_W;

   if (SAMPLE_W <= DATA_W || SAMPLE_W > 2*DATA_W) begin : g_bad_width
      $error("iq_tap_port: SAMPLE_W must exceed DATA_W and fit in two bytes");
   end
   if (int'(BASE_ADDR) > (2**ADDR_W) - int'(NUM_SLOT)) begin : g_bad_base
      $error("iq_tap_port: map does not fit in the address space");
   end

   logic              hit;
   slot_e             slot;
   logic [NUM_CH-1:0] rd_lo, wr_lo, wr_hi;

   iq_tap_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .hit      (hit),
      .slot     (slot),
      .rd_lo    (rd_lo),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi)
   );

   logic [SAMPLE_W-1:0] live_a [NUM_CH];
   logic [SAMPLE_W-1:0] dac_a  [NUM_CH];
   logic [DATA_W-1:0]   lo_b   [NUM_CH];
   logic [DATA_W-1:0]   hi_b   [NUM_CH];

   assign live_a[0] = live_i;
   assign live_a[1] = live_q;
   assign dac_i     = dac_a[0];
   assign dac_q     = dac_a[1];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      iq_tap_lane #(.SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .live_stb (live_stb),
         .live     (live_a[c]),
         .ovr_sel  (ovr_sel),
         .rd_lo    (rd_lo[c]),
         .wr_lo    (wr_lo[c]),
         .wr_hi    (wr_hi[c]),
         .wdata    (bus_wdata),
         .lo_byte  (lo_b[c]),
         .hi_byte  (hi_b[c]),
         .dac      (dac_a[c])
      );
   end

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      unique case (slot)
         SLOT_I_LO: rd_mux = lo_b[0];
         SLOT_I_HI: rd_mux = hi_b[0];
         SLOT_Q_LO: rd_mux = lo_b[1];
         default:   rd_mux = hi_b[1];
      endcase
      if (!hit) rd_mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   p_oob_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> bus_rdata == '0);

   p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit && (slot == SLOT_I_HI || slot == SLOT_Q_HI))
      |=> bus_rdata[DATA_W-1:HI_W] == '0);

   p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   p_lo_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && slot == SLOT_I_LO && hit) |=> bus_rdata == $past(live_i[DATA_W-1:0]));

   p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_lo, wr_lo, wr_hi}) || (bus_rd && bus_wr));
endmodule

// File: tb/iq_tap_port_tb.sv
module iq_tap_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        ovr_sel = 1'b0;
   logic        live_stb = 1'b0;
   logic [13:0] live_i = '0;
   logic [13:0] live_q = '0;
   logic [13:0] dac_i, dac_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   iq_tap_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ovr_sel(ovr_sel), .live_stb(live_stb), .live_i(live_i),
      .live_q(live_q), .dac_i(dac_i), .dac_q(dac_q)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic strobe(input logic [13:0] vi, input logic [13:0] vq);
      @(negedge clk);
      live_i = vi; live_q = vq; live_stb = 1'b1;
      @(negedge clk);
      live_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [13:0] ovi, ovq;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 rdata", {8'h0, bus_rdata}, 16'h0);
      chk("R10 dac_i", {2'b0, dac_i}, 16'h0);
      chk("R10 dac_q", {2'b0, dac_q}, 16'h0);
      live_i = 14'h3FFF; live_q = 14'h2AAA;
      // R4: high read before any low read returns reset hold (zero)
      bus_read(8'h51, d); chk("R4 I hold reset", {8'h0, d}, 16'h0);
      bus_read(8'h53, d); chk("R4 Q hold reset", {8'h0, d}, 16'h0);

      // R1 R2 R3 R5: sweep of spread values, live changed between halves
      for (int k = 0; k < 450; k++) begin
         logic [13:0] vi, vq;
         vi = 14'((k * 37) % 16384);
         vq = 14'((k * 185 + 123) % 16384);
         live_i = vi; live_q = vq;
         bus_read(8'h50, d); chk("R2 I low", {8'h0, d}, {8'h0, vi[7:0]});
         live_i = ~vi; live_q = ~vq;
         bus_read(8'h51, d); chk("R3 I high held", {8'h0, d}, {10'h0, vi[13:8]});
         live_q = vq;
         bus_read(8'h52, d); chk("R1 Q low", {8'h0, d}, {8'h0, vq[7:0]});
         live_q = ~vq;
         bus_read(8'h53, d); chk("R5 Q high held", {8'h0, d}, {10'h0, vq[13:8]});
      end

      // R4: repeated high read returns same hold, no low read between
      live_i = 14'h1234;
      bus_read(8'h50, d);
      live_i = 14'h0000;
      bus_read(8'h51, d); chk("R4 first", {8'h0, d}, 16'h0012);
      live_i = 14'h3F00;
      bus_read(8'h51, d); chk("R4 repeat", {8'h0, d}, 16'h0012);

      // R1: rdata holds with no read strobe
      repeat (3) @(negedge clk);
      chk("R1 rdata hold", {8'h0, bus_rdata}, 16'h0012);

      // R9: out-of-range reads return zero, hold untouched
      foreach (d[i]) ;
      bus_read(8'h4F, d); chk("R9 read 0x4F", {8'h0, d}, 16'h0);
      bus_read(8'h54, d); chk("R9 read 0x54", {8'h0, d}, 16'h0);
      bus_read(8'h00, d); chk("R9 read 0x00", {8'h0, d}, 16'h0);
      bus_read(8'hFF, d); chk("R9 read 0xFF", {8'h0, d}, 16'h0);
      bus_read(8'h51, d); chk("R9 hold intact", {8'h0, d}, 16'h0012);

      // R8: follow live strobes with override off
      ovr_sel = 1'b0;
      for (int k = 0; k < 40; k++) begin
         logic [13:0] vi, vq;
         vi = 14'((k * 409 + 7) % 16384);
         vq = 14'((k * 1021 + 3) % 16384);
         strobe(vi, vq);
         chk("R8 dac_i follow", {2'b0, dac_i}, {2'b0, vi});
         chk("R8 dac_q follow", {2'b0, dac_q}, {2'b0, vq});
         live_i = ~vi; live_q = ~vq;
         @(negedge clk);
         chk("R8 dac_i idle", {2'b0, dac_i}, {2'b0, vi});
      end

      // R10: override value reset to zero
      ovr_sel = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 ovr_i zero", {2'b0, dac_i}, 16'h0);
      chk("R10 ovr_q zero", {2'b0, dac_q}, 16'h0);

      // R6 R7: staged low, commit on high, sweep
      ovi = '0; ovq = '0;
      for (int k = 0; k < 64; k++) begin
         logic [13:0] wi, wq;
         wi = 14'((k * 263 + 11) % 16384);
         wq = 14'((k * 977 + 5) % 16384);
         bus_write(8'h50, wi[7:0]);
         bus_write(8'h52, wq[7:0]);
         @(negedge clk);
         chk("R6 I staged only", {2'b0, dac_i}, {2'b0, ovi});
         chk("R6 Q staged only", {2'b0, dac_q}, {2'b0, ovq});
         bus_write(8'h51, {2'b11, wi[13:8]});
         bus_write(8'h53, {2'b10, wq[13:8]});
         @(negedge clk);
         chk("R5 R7 I commit", {2'b0, dac_i}, {2'b0, wi});
         chk("R5 R7 Q commit", {2'b0, dac_q}, {2'b0, wq});
         ovi = wi; ovq = wq;
      end

      // R7: live strobes do not disturb override
      strobe(14'h0101, 14'h0202);
      strobe(14'h3333, 14'h1111);
      chk("R7 I no live", {2'b0, dac_i}, {2'b0, ovi});
      chk("R7 Q no live", {2'b0, dac_q}, {2'b0, ovq});

      // R9: writes outside the map are ignored
      bus_write(8'h54, 8'h3F);
      bus_write(8'h4F, 8'hAA);
      bus_write(8'h51, 8'h05);
      @(negedge clk);
      chk("R9 write ignored", {2'b0, dac_i}, {2'b0, {6'h05, ovi[7:0]}});
      chk("R9 Q untouched", {2'b0, dac_q}, {2'b0, ovq});

      // R8: leaving override returns to live tracking on strobe
      ovr_sel = 1'b0;
      strobe(14'h2468, 14'h1357);
      chk("R8 resume I", {2'b0, dac_i}, 16'h2468);
      chk("R8 resume Q", {2'b0, dac_q}, 16'h1357);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule